// File: doc/BRIEF.md
# Partial-Word Store Lane Generator

This block sits on the store side of a 32-bit processor's data-memory port. Each request carries a store opcode, a base register value, a 16-bit displacement and the register data to be written. From these it computes the effective address and produces four outputs. The first is the word-aligned address sent to memory. The second is a per-byte write-enable mask. The third is the write data with each register byte moved into the lane where it belongs. The last is an error flag for a full-word store that is not word aligned.

Besides plain word stores, the block handles the two partial stores that let software write a register to an address that is not word aligned. One of them writes the upper end of the register into the bytes at and below the target address within its word. The other writes the lower end of the register into the bytes at and above the target address. Issuing both covers the four bytes across a word boundary. Memory is little-endian: byte offset j within a word (effective address modulo 4) is lane j, carried on `mem_wdata[8j+7:8j]` and enabled by `mem_strb[j]`. All outputs are registered and appear one clock after the request.

Top module: `stl_store_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. `mem_word_addr` equals that address with its two low bits cleared, and it appears one cycle after a request.
- R2: A request with opcode 6'b101011 whose effective address has low bits 00 asserts `mem_we`, drives `mem_strb` to 4'b1111 and passes `req_data` unchanged on `mem_wdata`.
- R3: A request with opcode 6'b101011 whose effective address low bits are not 00 asserts `addr_err`, holds `mem_we` low and drives `mem_strb` to zero.
- R4: A request with opcode 6'b101010 at byte offset k enables lanes 0 through k. Lane j carries register byte 3-k+j, so the register's most significant byte lands at offset k.
- R5: A request with opcode 6'b101110 at byte offset k enables lanes k through 3. Lane j carries register byte j-k, so the register's least significant byte lands at offset k.
- R6: Requests with opcode 6'b101010 or 6'b101110 never assert `addr_err`, and at every offset they write at least one byte.
- R7: A 6'b101110 store to address A followed by a 6'b101010 store to address A+3, both with the same data, leaves register bytes 0..3 at memory bytes A..A+3 for every alignment of A.
- R8: A cycle without `req_valid`, or a request with any other opcode, produces `mem_we`=0, `mem_strb`=0 and `addr_err`=0 in the following cycle.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store request present this cycle |
| req_opcode | input | 6 | Primary opcode of the store instruction |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_data | input | 32 | Register value to be stored |
| mem_we | output | 1 | Memory write request |
| mem_word_addr | output | 32 | Effective address with the two low bits cleared |
| mem_strb | output | 4 | Per-lane byte enables, bit j for byte offset j |
| mem_wdata | output | 32 | Lane-aligned write data |
| addr_err | output | 1 | Misaligned full-word store detected |

## Verification
Every result passes through exactly one register, so the outputs for a request are due one clock after the edge that captures it. The bench drives each request on a falling edge and reads the outputs on the next falling edge, which falls half a period after the capturing rising edge and before the next request is applied. The paired-store test applies each sampled write to a byte-array model at that same falling edge. The final memory bytes are then compared, which checks the combined effect two cycles after the first store of the pair.

// File: rtl/stl_pkg.sv
package stl_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned NLANES = XLEN / 8;
    localparam int unsigned OFS_W  = $clog2(NLANES);

    localparam logic [5:0] OPC_WORD  = 6'b101011;
    localparam logic [5:0] OPC_LEFT  = 6'b101010;
    localparam logic [5:0] OPC_RIGHT = 6'b101110;

    typedef enum logic [1:0] {
        ST_NONE  = 2'd0,
        ST_WORD  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } st_kind_e;

    typedef struct packed {
        logic              we;
        logic              err;
        logic [XLEN-1:0]   addr;
        logic [NLANES-1:0] strb;
        logic [XLEN-1:0]   wdata;
    } st_out_t;

endpackage

// File: rtl/stl_ea_adder.sv
module stl_ea_adder #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IMM_W = 16,
    parameter int unsigned OFS_W = 2
) (
    input  logic [XLEN-1:0]  base_i,
    input  logic [IMM_W-1:0] disp_i,
    output logic [XLEN-1:0]  ea_o,
    output logic [XLEN-1:0]  word_addr_o,
    output logic [OFS_W-1:0] byte_ofs_o
);
    localparam int unsigned EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] disp_sx;

    always_comb begin
        disp_sx     = {{EXT_W{disp_i[IMM_W-1]}}, disp_i};
        ea_o        = base_i + disp_sx;
        word_addr_o = {ea_o[XLEN-1:OFS_W], {OFS_W{1'b0}}};
        byte_ofs_o  = ea_o[OFS_W-1:0];
    end
endmodule

// File: rtl/stl_op_decode.sv
module stl_op_decode
    import stl_pkg::*;
#(
    parameter int unsigned OFS_W = 2
) (
    input  logic             valid_i,
    input  logic [5:0]       opcode_i,
    input  logic [OFS_W-1:0] byte_ofs_i,
    output st_kind_e         kind_o,
    output logic             misalign_o
);
    always_comb begin
        kind_o     = ST_NONE;
        misalign_o = 1'b0;
        if (valid_i) begin
            unique case (opcode_i)
                OPC_WORD: begin
                    if (byte_ofs_i == '0) kind_o = ST_WORD;
                    else                  misalign_o = 1'b1;
                end
                OPC_LEFT:  kind_o = ST_LEFT;
                OPC_RIGHT: kind_o = ST_RIGHT;
                default:   kind_o = ST_NONE;
            endcase
        end
    end
endmodule

// File: rtl/stl_lane_mux.sv
module stl_lane_mux
    import stl_pkg::*;
#(
    parameter int unsigned NLANES = 4,
    parameter int unsigned OFS_W  = 2
) (
    input  st_kind_e            kind_i,
    input  logic [OFS_W-1:0]    byte_ofs_i,
    input  logic [NLANES*8-1:0] data_i,
    output logic [NLANES-1:0]   strb_o,
    output logic [NLANES*8-1:0] wdata_o
);
    localparam logic [OFS_W-1:0] TOP_LANE = OFS_W'(NLANES - 1);

    for (genvar j = 0; j < NLANES; j++) begin : g_lane
        localparam logic [OFS_W-1:0] LANE = OFS_W'(j);
        logic             en_d;
        logic [OFS_W-1:0] src_d;

        always_comb begin
            en_d  = 1'b0;
            src_d = '0;
            unique case (kind_i)
                ST_WORD: begin
                    en_d  = 1'b1;
                    src_d = LANE;
                end
                ST_LEFT: begin
                    en_d  = (LANE <= byte_ofs_i);
                    src_d = TOP_LANE - byte_ofs_i + LANE;
                end
                ST_RIGHT: begin
                    en_d  = (LANE >= byte_ofs_i);
                    src_d = LANE - byte_ofs_i;
                end
                default: begin
                    en_d  = 1'b0;
                    src_d = '0;
                end
            endcase
        end

        assign strb_o[j]        = en_d;
        assign wdata_o[8*j +: 8] = en_d ? data_i[8*src_d +: 8] : 8'h00;
    end
endmodule

// File: rtl/stl_store_unit.sv
module stl_store_unit
    import stl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [5:0]        req_opcode,
    input  logic [XLEN-1:0]   req_base,
    input  logic [IMM_W-1:0]  req_offset,
    input  logic [XLEN-1:0]   req_data,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_word_addr,
    output logic [NLANES-1:0] mem_strb,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              addr_err
);
    logic [XLEN-1:0]   ea;
    logic [XLEN-1:0]   word_addr;
    logic [OFS_W-1:0]  byte_ofs;
    st_kind_e          kind;
    logic              misalign;
    logic [NLANES-1:0] lane_strb;
    logic [XLEN-1:0]   lane_data;
    st_out_t           out_d, out_q;

    stl_ea_adder #(.XLEN(XLEN), .IMM_W(IMM_W), .OFS_W(OFS_W)) u_ea (
        .base_i      (req_base),
        .disp_i      (req_offset),
        .ea_o        (ea),
        .word_addr_o (word_addr),
        .byte_ofs_o  (byte_ofs)
    );

    stl_op_decode #(.OFS_W(OFS_W)) u_dec (
        .valid_i    (req_valid),
        .opcode_i   (req_opcode),
        .byte_ofs_i (byte_ofs),
        .kind_o     (kind),
        .misalign_o (misalign)
    );

    stl_lane_mux #(.NLANES(NLANES), .OFS_W(OFS_W)) u_lanes (
        .kind_i     (kind),
        .byte_ofs_i (byte_ofs),
        .data_i     (req_data),
        .strb_o     (lane_strb),
        .wdata_o    (lane_data)
    );

    always_comb begin
        out_d       = '0;
        out_d.we    = (kind != ST_NONE);
        out_d.err   = misalign;
        out_d.addr  = word_addr;
        out_d.strb  = lane_strb;
        out_d.wdata = lane_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign mem_we        = out_q.we;
    assign addr_err      = out_q.err;
    assign mem_word_addr = out_q.addr;
    assign mem_strb      = out_q.strb;
    assign mem_wdata     = out_q.wdata;

    p_misaligned_word_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opcode == OPC_WORD && ea[OFS_W-1:0] != '0)
        |=> (addr_err && !mem_we && mem_strb == '0));

    p_aligned_word_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opcode == OPC_WORD && ea[OFS_W-1:0] == '0)
        |=> (mem_we && mem_strb == '1 && mem_wdata == $past(req_data)));

    p_left_hits_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opcode == OPC_LEFT)
        |=> (mem_we && mem_strb[0] && !addr_err));

    p_right_hits_top_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opcode == OPC_RIGHT)
        |=> (mem_we && mem_strb[NLANES-1] && !addr_err));

    p_partial_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_opcode == OPC_LEFT || req_opcode == OPC_RIGHT))
        |=> ($countones(mem_strb) >= 1 && !addr_err));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && (req_opcode == OPC_WORD || req_opcode == OPC_LEFT
                        || req_opcode == OPC_RIGHT))
        |=> (!mem_we && !addr_err && mem_strb == '0));

endmodule

// File: tb/stl_store_unit_tb.sv
module stl_store_unit_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_opcode = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_data = '0;
    logic        mem_we;
    logic [31:0] mem_word_addr;
    logic [3:0]  mem_strb;
    logic [31:0] mem_wdata;
    logic        addr_err;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mem_b [0:31];

    always #(CLK_PERIOD/2) clk = ~clk;

    stl_store_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_base(req_base), .req_offset(req_offset), .req_data(req_data),
        .mem_we(mem_we), .mem_word_addr(mem_word_addr), .mem_strb(mem_strb),
        .mem_wdata(mem_wdata), .addr_err(addr_err)
    );

    task automatic check(input string req, input logic [72:0] act, input logic [72:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_mask(input logic [3:0] s);
        logic [31:0] m;
        for (int j = 0; j < 4; j++) m[8*j +: 8] = {8{s[j]}};
        return m;
    endfunction

    // Drive at a falling edge, capture at the rising edge, sample at the next falling edge.
    task automatic issue(input logic v, input logic [5:0] op, input logic [31:0] b,
                         input logic [15:0] off, input logic [31:0] d);
        logic [31:0] ea;
        logic [1:0]  k;
        logic        e_we, e_err;
        logic [3:0]  e_strb;
        logic [31:0] e_data;
        string       tag;
        req_valid = v; req_opcode = op; req_base = b; req_offset = off; req_data = d;
        ea = b + {{16{off[15]}}, off};
        k  = ea[1:0];
        e_we = 1'b0; e_err = 1'b0; e_strb = 4'h0; e_data = 32'h0; tag = "R8";
        if (v && op == 6'b101011) begin
            if (k == 2'd0) begin
                e_we = 1'b1; e_strb = 4'hF; e_data = d; tag = "R2";
            end else begin
                e_err = 1'b1; tag = "R3";
            end
        end else if (v && op == 6'b101010) begin
            e_we = 1'b1; tag = "R4/R6";
            for (int j = 0; j < 4; j++)
                if (j <= int'(k)) begin
                    e_strb[j] = 1'b1;
                    e_data[8*j +: 8] = d[8*(3 - int'(k) + j) +: 8];
                end
        end else if (v && op == 6'b101110) begin
            e_we = 1'b1; tag = "R5/R6";
            for (int j = 0; j < 4; j++)
                if (j >= int'(k)) begin
                    e_strb[j] = 1'b1;
                    e_data[8*j +: 8] = d[8*(j - int'(k)) +: 8];
                end
        end
        @(negedge clk);
        check(tag, {mem_we, addr_err, 4'(mem_strb), mem_wdata & lane_mask(mem_strb), 3'b0},
                   {e_we, e_err, e_strb, e_data, 3'b0});
        if (e_we) check("R1 word address", {41'b0, mem_word_addr}, {41'b0, ea[31:2], 2'b00});
        if (mem_we && mem_word_addr < 32'd32)
            for (int j = 0; j < 4; j++)
                if (mem_strb[j]) mem_b[mem_word_addr[4:0] + 5'(j)] = mem_wdata[8*j +: 8];
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [15:0] offs [4];
        logic [31:0] datas [2];
        logic [5:0]  ops [4];
        offs  = '{16'h0000, 16'h0005, 16'hFFFF, 16'h8000};
        datas = '{32'hA1B2C3D4, 32'h0F1E2D3C};
        ops   = '{6'b101011, 6'b101010, 6'b101110, 6'b100011};

        @(negedge clk);
        check("R9 reset", {mem_we, addr_err, 4'(mem_strb), mem_wdata, 3'b0}, 73'b0);
        check("R9 reset addr", {41'b0, mem_word_addr}, 73'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Idle cycle with a word opcode but no valid (R8)
        issue(1'b0, 6'b101011, 32'h100, 16'h0, 32'hFFFFFFFF);

        // Sweep opcodes x base alignment x displacement x data (R1..R6, R8)
        for (int o = 0; o < 4; o++)
            for (int a = 0; a < 4; a++)
                for (int f = 0; f < 4; f++)
                    for (int d = 0; d < 2; d++)
                        issue(1'b1, ops[o], 32'h00012340 + 32'(a), offs[f], datas[d]);

        // Paired partial stores across every alignment (R7)
        for (int a = 0; a < 4; a++) begin
            logic [31:0] dv;
            logic [31:0] addr_a;
            dv = 32'h11223344 + 32'(a) * 32'h01010101;
            addr_a = 32'd8 + 32'(a);
            for (int i = 0; i < 32; i++) mem_b[i] = 8'hEE;
            issue(1'b1, 6'b101110, addr_a, 16'h0000, dv);
            issue(1'b1, 6'b101010, addr_a - 32'd1, 16'h0004, dv);
            for (int j = 0; j < 4; j++)
                check("R7 paired bytes", {65'b0, mem_b[addr_a[4:0] + 5'(j)]},
                      {65'b0, dv[8*j +: 8]});
            check("R7 byte below untouched", {65'b0, mem_b[addr_a[4:0] - 5'd1]}, {65'b0, 8'hEE});
            check("R7 byte above untouched", {65'b0, mem_b[addr_a[4:0] + 5'd4]}, {65'b0, 8'hEE});
        end

        issue(1'b0, 6'b101010, 32'h0, 16'h0, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule